// File: doc/BRIEF.md
# Counter CSR Access Checker

This block decides whether an instruction that names one of the user-level counter CSRs may proceed. It covers the cycle, time and retired-instruction counters, the 29 programmable event counters, and the upper-half copies that a 32-bit core uses to read the top word. The block takes the CSR address, the current privilege level, a virtualization flag, a base-width flag, three per-counter enable masks and a mask of the event counters that are built. From these it returns one of three verdicts: allowed, illegal-instruction fault or virtual-instruction fault.

The core's CSR stage presents a request with a single-cycle valid strobe. The verdict comes back on the next clock edge with a matching valid pulse, so the trap logic can pick it up from a register instead of a long combinational path. The counters themselves, the read data and trap entry are handled elsewhere.

The checks follow a fixed priority. Address decode comes first, then the implemented-counter check, then the privilege enables. The virtualization check is last, and it can only fault when every earlier check has passed.

Top module: `ctr_access_chk`

## Requirements
- R1: A request with `reqValid` high produces `rspValid` high on the next rising clock edge and on no other edge. `rspResult` encodes 2'b00 allowed, 2'b01 illegal-instruction and 2'b10 virtual-instruction, and never 2'b11.
- R2: While `rst_n` is low, `rspValid` and `rspResult` are both 0.
- R3: Addresses 0xC00 to 0xC1F select counter index `addr - 0xC00`. Addresses 0xC80 to 0xC9F select index `addr - 0xC80`, but only when `isRv32` is 1. Any other address, and any upper-half address while `isRv32` is 0, gives illegal-instruction.
- R4: Indices 0, 1 and 2 bypass `implMask`. Any higher index whose `implMask` bit is 0 gives illegal-instruction at every privilege level.
- R5: `priv` encodes 2'b00 user, 2'b01 supervisor, and 2'b10 or 2'b11 machine. At machine level, a request that passes R3 and R4 is allowed whatever the enable masks and `virtOn` hold.
- R6: At supervisor level, a 0 at the counter's index in `mEn` gives illegal-instruction.
- R7: At user level, a 0 at the counter's index in `sEn` gives illegal-instruction. `mEn` does not gate user access outside the virtualization check.
- R8: With `virtOn` set at user or supervisor level, a request that passes R3 to R7 and finds its `hEn` bit at 0 while its `mEn` bit is 1 gives virtual-instruction. Otherwise it is allowed.
- R9: With `virtOn` set, a 0 `mEn` bit never produces virtual-instruction. A user-level request with its `sEn` bit set is then allowed even if its `hEn` bit is 0.
- R10: Every illegal-instruction condition takes priority over virtual-instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, one cycle per check |
| reqAddr | input | 12 | CSR address being accessed |
| priv | input | 2 | Current privilege level |
| virtOn | input | 1 | Virtualization active |
| isRv32 | input | 1 | Core runs with 32-bit base width |
| mEn | input | 32 | Machine-level counter enable mask |
| sEn | input | 32 | Supervisor-level counter enable mask |
| hEn | input | 32 | Hypervisor-level counter enable mask |
| implMask | input | 32 | One bit per built counter |
| rspValid | output | 1 | Verdict valid, one cycle after request |
| rspResult | output | 2 | Verdict code |

## Verification
A table of directed vectors walks each priority step in turn, including the two cases that separate a correct virtual check from the flawed shortcut: supervisor with the machine bit clear, which must give illegal, and user with the machine bit clear, which must be allowed. A sweep then covers every index in the lower window, the upper window and an out-of-range window. For each index it tries all privilege codes, both virtualization and width flags, and every value of the four relevant enable bits, and compares the result against an independent reference model. The enable masks carry the opposite value at every other index, so a wrong index selection changes the verdict. Directed tests cover the reset state, back-to-back requests, idle cycles and a reset applied mid-run.

// File: rtl/ctr_chk_pkg.sv
package ctr_chk_pkg;

  typedef enum logic [1:0] {
    RES_OK      = 2'b00,
    RES_ILLEGAL = 2'b01,
    RES_VIRT    = 2'b10
  } accessRes_e;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_RSVD  = 2'b10,
    PRIV_MACH  = 2'b11
  } privLvl_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
  } ctrlStrobe_t;

endpackage

// File: rtl/ctr_chk_decode.sv
module ctr_chk_decode #(
  parameter int ADDR_W    = 12,
  parameter int NUM_CTR   = 32,
  parameter int NUM_FIXED = 3,
  parameter logic [ADDR_W-1:0] LO_BASE = 12'hC00,
  parameter logic [ADDR_W-1:0] HI_BASE = 12'hC80
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               isRv32,
  output logic               inWindow,
  output logic               isFixed,
  output logic [NUM_CTR-1:0] idxOneHot
);
  localparam int IDX_W = $clog2(NUM_CTR);

  logic [IDX_W-1:0] idx;
  logic loHit, hiHit;

  assign idx   = addr[IDX_W-1:0];
  assign loHit = (addr[ADDR_W-1:IDX_W] == LO_BASE[ADDR_W-1:IDX_W]);
  assign hiHit = (addr[ADDR_W-1:IDX_W] == HI_BASE[ADDR_W-1:IDX_W]) && isRv32;
  assign inWindow = loHit || hiHit;
  assign isFixed  = (32'(idx) < NUM_FIXED);

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_sel
    assign idxOneHot[g] = inWindow && (32'(idx) == g);
  end

endmodule

// File: rtl/ctr_chk_eval.sv
module ctr_chk_eval
  import ctr_chk_pkg::*;
#(
  parameter int NUM_CTR = 32
) (
  input  logic [NUM_CTR-1:0] idxOneHot,
  input  logic               inWindow,
  input  logic               isFixed,
  input  logic [1:0]         priv,
  input  logic               virtOn,
  input  logic [NUM_CTR-1:0] mEn,
  input  logic [NUM_CTR-1:0] sEn,
  input  logic [NUM_CTR-1:0] hEn,
  input  logic [NUM_CTR-1:0] implMask,
  output accessRes_e         verdict
);
  logic mBit, sBit, hBit, implBit, isMach;
  privLvl_e lvl;

  assign mBit    = |(mEn & idxOneHot);
  assign sBit    = |(sEn & idxOneHot);
  assign hBit    = |(hEn & idxOneHot);
  assign implBit = |(implMask & idxOneHot);
  assign lvl     = privLvl_e'(priv);
  assign isMach  = (lvl == PRIV_MACH) || (lvl == PRIV_RSVD);

  always_comb begin
    verdict = RES_OK;
    if (!inWindow) begin
      verdict = RES_ILLEGAL;
    end else if (!isFixed && !implBit) begin
      verdict = RES_ILLEGAL;
    end else if (isMach) begin
      verdict = RES_OK;
    end else if (lvl == PRIV_SUPER && !mBit) begin
      verdict = RES_ILLEGAL;
    end else if (lvl == PRIV_USER && !sBit) begin
      verdict = RES_ILLEGAL;
    end else if (virtOn && mBit && !hBit) begin
      verdict = RES_VIRT;
    end
  end

endmodule

// File: rtl/ctr_chk_ctrl.sv
module ctr_chk_ctrl
  import ctr_chk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  output ctrlStrobe_t strobe,
  output logic        rspValid
);
  logic validQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validQ <= 1'b0;
    else        validQ <= reqValid;
  end

  assign strobe.capture = reqValid;
  assign rspValid       = validQ;

endmodule

// File: rtl/ctr_chk_datapath.sv
module ctr_chk_datapath
  import ctr_chk_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_CTR   = 32,
  parameter int NUM_FIXED = 3,
  parameter logic [ADDR_W-1:0] LO_BASE = 12'hC00,
  parameter logic [ADDR_W-1:0] HI_BASE = 12'hC80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobe_t        strobe,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         priv,
  input  logic               virtOn,
  input  logic               isRv32,
  input  logic [NUM_CTR-1:0] mEn,
  input  logic [NUM_CTR-1:0] sEn,
  input  logic [NUM_CTR-1:0] hEn,
  input  logic [NUM_CTR-1:0] implMask,
  output logic [1:0]         rspResult
);
  logic               inWindow, isFixed;
  logic [NUM_CTR-1:0] idxOneHot;
  accessRes_e         verdict, resQ;

  ctr_chk_decode #(
    .ADDR_W(ADDR_W), .NUM_CTR(NUM_CTR), .NUM_FIXED(NUM_FIXED),
    .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
  ) u_decode (
    .addr(reqAddr), .isRv32(isRv32),
    .inWindow(inWindow), .isFixed(isFixed), .idxOneHot(idxOneHot)
  );

  ctr_chk_eval #(.NUM_CTR(NUM_CTR)) u_eval (
    .idxOneHot(idxOneHot), .inWindow(inWindow), .isFixed(isFixed),
    .priv(priv), .virtOn(virtOn),
    .mEn(mEn), .sEn(sEn), .hEn(hEn), .implMask(implMask),
    .verdict(verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              resQ <= RES_OK;
    else if (strobe.capture) resQ <= verdict;
  end

  assign rspResult = resQ;

endmodule

// File: rtl/ctr_access_chk.sv
module ctr_access_chk
  import ctr_chk_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_CTR   = 32,
  parameter int NUM_FIXED = 3,
  parameter logic [ADDR_W-1:0] LO_BASE = 12'hC00,
  parameter logic [ADDR_W-1:0] HI_BASE = 12'hC80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         priv,
  input  logic               virtOn,
  input  logic               isRv32,
  input  logic [NUM_CTR-1:0] mEn,
  input  logic [NUM_CTR-1:0] sEn,
  input  logic [NUM_CTR-1:0] hEn,
  input  logic [NUM_CTR-1:0] implMask,
  output logic               rspValid,
  output logic [1:0]         rspResult
);
  ctrlStrobe_t strobe;

  ctr_chk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .strobe(strobe), .rspValid(rspValid)
  );

  ctr_chk_datapath #(
    .ADDR_W(ADDR_W), .NUM_CTR(NUM_CTR), .NUM_FIXED(NUM_FIXED),
    .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .reqAddr(reqAddr), .priv(priv), .virtOn(virtOn), .isRv32(isRv32),
    .mEn(mEn), .sEn(sEn), .hEn(hEn), .implMask(implMask),
    .rspResult(rspResult)
  );

endmodule

// File: rtl/ctr_chk_sva.sv
module ctr_chk_sva #(
  parameter int ADDR_W  = 12,
  parameter int NUM_CTR = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reqValid,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic [1:0]         priv,
  input logic               virtOn,
  input logic [NUM_CTR-1:0] mEn,
  input logic               rspValid,
  input logic [1:0]         rspResult
);
  localparam int IDX_W = $clog2(NUM_CTR);

  // R1: response strobe mirrors the previous cycle's request strobe
  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid == $past(reqValid));

  // R1: the unused code never appears on a valid response
  p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> rspResult != 2'b11);

  // R9: a virtual fault needs the machine enable bit of the accessed counter
  p_virt_needs_mbit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspResult == 2'b10) |-> $past(mEn[reqAddr[IDX_W-1:0]]));

  // R8: a virtual fault needs virtualization and a non-machine level
  p_virt_needs_guest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspResult == 2'b10) |-> ($past(virtOn) && !$past(priv[1])));

  // R5: machine level access to a fixed counter in the lower window is allowed
  p_machine_fixed_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reqValid && priv[1] && reqAddr[ADDR_W-1:IDX_W] == 7'h60 && reqAddr[IDX_W-1:0] < 3)
      |-> rspResult == 2'b00);

endmodule

bind ctr_access_chk ctr_chk_sva #(.ADDR_W(ADDR_W), .NUM_CTR(NUM_CTR)) u_sva (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
  .priv(priv), .virtOn(virtOn), .mEn(mEn),
  .rspValid(rspValid), .rspResult(rspResult)
);

// File: tb/ctr_access_chk_tb.sv
module ctr_access_chk_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // fields: addr[21:10] priv[9:8] virt[7] rv32[6] m[5] s[4] h[3] impl[2] exp[1:0]
  localparam logic [NV-1:0][21:0] VEC = {
    {12'hC00, 2'd1, 1'b0, 1'b0, 4'b1111, 2'd0},  // R6 supervisor allowed
    {12'hC00, 2'd1, 1'b0, 1'b0, 4'b0111, 2'd1},  // R6 supervisor, m clear
    {12'hC01, 2'd0, 1'b0, 1'b0, 4'b1011, 2'd1},  // R7 user, s clear
    {12'hC01, 2'd0, 1'b0, 1'b0, 4'b0111, 2'd0},  // R7 user ignores m
    {12'hC05, 2'd0, 1'b0, 1'b0, 4'b1110, 2'd1},  // R4 not implemented
    {12'hC02, 2'd0, 1'b0, 1'b0, 4'b0110, 2'd0},  // R4 fixed counter bypass
    {12'hC85, 2'd1, 1'b0, 1'b1, 4'b1111, 2'd0},  // R3 upper half on 32-bit
    {12'hC85, 2'd1, 1'b0, 1'b0, 4'b1111, 2'd1},  // R3 upper half on 64-bit
    {12'hC20, 2'd3, 1'b0, 1'b1, 4'b1111, 2'd1},  // R3 outside window
    {12'hC03, 2'd3, 1'b1, 1'b0, 4'b0001, 2'd0},  // R5 machine ignores masks
    {12'hC04, 2'd1, 1'b1, 1'b0, 4'b1101, 2'd2},  // R8 virtual fault
    {12'hC04, 2'd0, 1'b1, 1'b0, 4'b0101, 2'd0},  // R9 user, m clear, allowed
    {12'hC04, 2'd1, 1'b1, 1'b0, 4'b0101, 2'd1},  // R9 supervisor, m clear
    {12'hC1F, 2'd0, 1'b1, 1'b0, 4'b1001, 2'd1},  // R10 illegal beats virtual
    {12'hC9F, 2'd0, 1'b1, 1'b1, 4'b1111, 2'd0},  // R8 all enables set
    {12'hC83, 2'd2, 1'b1, 1'b1, 4'b1110, 2'd1}   // R4 machine, not implemented
  };

  logic        clk = 0, rst_n = 0, reqValid = 0, virtOn = 0, isRv32 = 0;
  logic [11:0] reqAddr = '0;
  logic [1:0]  priv = '0;
  logic [31:0] mEn = '0, sEn = '0, hEn = '0, implMask = '0;
  logic        rspValid;
  logic [1:0]  rspResult;
  int nRun = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr_access_chk u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .priv(priv), .virtOn(virtOn), .isRv32(isRv32),
    .mEn(mEn), .sEn(sEn), .hEn(hEn), .implMask(implMask),
    .rspValid(rspValid), .rspResult(rspResult)
  );

  function automatic logic [1:0] refModel(logic [11:0] a, logic [1:0] p, logic v, logic w,
                                          logic [31:0] m, logic [31:0] s, logic [31:0] h,
                                          logic [31:0] im);
    int k;
    if (!(a[11:5] == 7'h60 || (a[11:5] == 7'h64 && w))) return 2'd1;
    k = int'(a[4:0]);
    if (k >= 3 && !im[k]) return 2'd1;
    if (p >= 2) return 2'd0;
    if (p == 1 && !m[k]) return 2'd1;
    if (p == 0 && !s[k]) return 2'd1;
    if (v && m[k] && !h[k]) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] maskFor(logic bitVal, logic [4:0] k);
    logic [31:0] one = 32'h1 << k;
    return bitVal ? one : ~one;
  endfunction

  task automatic issue(logic [11:0] a, logic [1:0] p, logic v, logic w,
                       logic m, logic s, logic h, logic im);
    @(negedge clk);
    reqAddr = a; priv = p; virtOn = v; isRv32 = w;
    mEn = maskFor(m, a[4:0]); sEn = maskFor(s, a[4:0]);
    hEn = maskFor(h, a[4:0]); implMask = maskFor(im, a[4:0]);
    reqValid = 1;
    @(negedge clk);
    reqValid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset valid", {1'b0, rspValid}, 2'd0);
    check("R2 reset result", rspResult, 2'd0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][21:10], VEC[i][9:8], VEC[i][7], VEC[i][6],
            VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      check($sformatf("R1 vector %0d valid", i), {1'b0, rspValid}, 2'd1);
      check($sformatf("R3-table vector %0d result (R4 R5 R6 R7 R8 R9 R10)", i),
            rspResult, VEC[i][1:0]);
    end

    @(negedge clk);
    check("R1 idle no valid", {1'b0, rspValid}, 2'd0);

    // R1 back-to-back requests
    @(negedge clk);
    reqAddr = 12'hC04; priv = 2'd1; virtOn = 1; isRv32 = 0;
    mEn = 32'h10; sEn = '0; hEn = '0; implMask = 32'h10; reqValid = 1;
    @(negedge clk);
    check("R1 b2b first valid", {1'b0, rspValid}, 2'd1);
    check("R8 b2b first", rspResult, 2'd2);
    mEn = '0;
    @(negedge clk);
    reqValid = 0;
    check("R1 b2b second valid", {1'b0, rspValid}, 2'd1);
    check("R9 b2b second", rspResult, 2'd1);

    // exhaustive sweep against reference model
    for (int win = 0; win < 3; win++)
      for (int k = 0; k < 32; k++)
        for (int p = 0; p < 4; p++)
          for (int vw = 0; vw < 4; vw++)
            for (int b = 0; b < 16; b++) begin
              logic [11:0] a;
              logic [1:0] exp;
              a = (win == 0 ? 12'hC00 : (win == 1 ? 12'hC80 : 12'hCA0)) + 12'(k);
              issue(a, 2'(p), vw[0], vw[1], b[3], b[2], b[1], b[0]);
              exp = refModel(a, 2'(p), vw[0], vw[1], mEn, sEn, hEn, implMask);
              check($sformatf("R3 sweep addr %h priv %0d vw %0d bits %0d (R4..R10)",
                              a, p, vw, b), rspResult, exp);
            end

    // R2 reset mid-run
    issue(12'hC00, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    rst_n = 0;
    #1;
    check("R2 mid-run valid", {1'b0, rspValid}, 2'd0);
    check("R2 mid-run result", rspResult, 2'd0);
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule